// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of an open SDRAM row through the beats of a read or write burst. When a read or write command is issued, the command path pulses `start_i` together with the starting column, the burst length code and the burst order taken from the mode register. From the next cycle on, the block presents one column per cycle on `col_o`, with `beat_vld_o` high while a beat is present and `last_o` marking the final beat of a burst of fixed length.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned block of columns that holds the start column. The beat order is either sequential (the low column bits count up and wrap) or interleaved (the low column bits are the start bits XOR the beat index). A full-page burst counts through every column of the row, wraps at the end of the page and runs until a burst stop, a precharge or a new command ends it. A new start in the middle of a burst drops the rest of the old burst and restarts at the new column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset and before any start, `beat_vld_o` and `last_o` are low.
- R2: The cycle after `start_i` is sampled high, `beat_vld_o` is high and `col_o` equals the sampled `start_col_i`; each following beat advances one per cycle.
- R3: Length codes on `blen_i` are 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. With `btype_i` = 0 (sequential), beat k of a 2, 4 or 8 beat burst carries low bits equal to (start low bits + k) modulo the length.
- R4: With `btype_i` = 1 (interleaved), beat k of a 2, 4 or 8 beat burst carries low bits equal to the start low bits XOR k.
- R5: During a fixed-length burst, the column bits above the burst block keep the start column's value on every beat.
- R6: Length code 0 and the unused codes 4, 5 and 6 give a single beat at the start column, flagged as last.
- R7: `last_o` is high only together with `beat_vld_o`, exactly on the final beat of a fixed-length burst; without a new start the next cycle has no beat.
- R8: A full-page burst (code 7) presents start+k modulo 2^COL_W on beat k whatever `btype_i` says, wraps past the page end, keeps running and never raises `last_o`.
- R9: `stop_i` sampled high during a burst (without `start_i`) ends it: the next cycle has no beat.
- R10: `pre_term_i` sampled high during a burst (without `start_i`) ends it the same way.
- R11: `start_i` during a burst restarts at the new column with the new length and order and drops the old burst's remaining beats; `start_i` wins over `stop_i` or `pre_term_i` in the same cycle.
- R12: A start sampled on the final beat of a burst gives a next burst whose first beat follows with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Read or write command issued this cycle |
| start_col_i | input | COL_W | Column carried by the command |
| blen_i | input | 3 | Burst length code |
| btype_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst stop command issued this cycle |
| pre_term_i | input | 1 | Precharge to the burst's bank issued this cycle |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The assertions take for granted that the length code and order are only meaningful when sampled with `start_i`, and the checker latches them at that moment rather than trusting the live inputs during the burst. They also assume `stop_i` and `pre_term_i` may arrive in any cycle, including together with a start, so the bench drives them idle, mid-burst, and in the same cycle as a new start. Stimulus only changes inputs just after a rising edge, and holds each command for exactly one cycle, as a command path would.

// File: rtl/colgen_pkg.sv
// Shared encodings and helpers for the burst column generator.
// Assumes a 3-bit length code; burst blocks never exceed 8 columns.
package colgen_pkg;

    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

    // Burst settings latched when a command starts a burst.
    typedef struct packed {
        logic       page;   // full-page burst
        logic       ilv;    // interleaved order
        logic [2:0] span;   // beats minus one for fixed lengths
    } burst_cfg_t;

    // Beats minus one for a length code; unused codes give one beat.
    function automatic logic [2:0] span_of(input logic [2:0] code);
        case (code)
            LEN_2:   span_of = 3'd1;
            LEN_4:   span_of = 3'd3;
            LEN_8:   span_of = 3'd7;
            default: span_of = 3'd0;
        endcase
    endfunction

    // Turns the command-time inputs into a burst setting.
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic ilv);
        burst_cfg_t c;
        c.page = (code == LEN_PAGE);
        c.ilv  = ilv;
        c.span = span_of(code);
        return c;
    endfunction

endpackage

// File: rtl/colgen_ctrl.sv
// Burst sequencing state: holds the start column, the beat index and the
// latched burst setting, and decides when a burst ends.
// Assumes start has priority over burst stop and precharge termination.
module colgen_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             stop_i,
    input  logic             pre_term_i,
    output logic             active_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output burst_cfg_t       cfg_o,
    output logic             final_o
);

    localparam int PAD_W = COL_W - 3;

    logic             active_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] cnt_q;
    burst_cfg_t       cfg_q;
    logic             at_end;

    // Final beat of a fixed-length burst is reached when the index hits the span.
    always_comb begin
        at_end = active_q && !cfg_q.page && (cnt_q == {{PAD_W{1'b0}}, cfg_q.span});
    end

    // Load on a command, clear on termination or completion, else step the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            base_q   <= start_col_i;
            cnt_q    <= '0;
            cfg_q    <= cfg_i;
        end else if (stop_i || pre_term_i || at_end) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + COL_W'(1);
        end
    end

    assign active_o = active_q;
    assign base_o   = base_q;
    assign cnt_o    = cnt_q;
    assign cfg_o    = cfg_q;
    assign final_o  = at_end;

endmodule

// File: rtl/colgen_addr.sv
// Column computation for the current beat from the start column and the
// beat index. Bits inside the burst block take the sequential or
// interleaved value; bits above it keep the start column. A full-page
// burst uses a plain wrapping sum over the whole column.
// Assumes COL_W is at least 3.
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    localparam int PAD_W = COL_W - 3;

    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] ilv_val;
    logic [COL_W-1:0] pick;
    logic [COL_W-1:0] blk_mask;

    // Both orderings and the block mask for the current beat.
    always_comb begin
        seq_val  = base_i + cnt_i;
        ilv_val  = base_i ^ cnt_i;
        pick     = (cfg_i.ilv && !cfg_i.page) ? ilv_val : seq_val;
        blk_mask = cfg_i.page ? {COL_W{1'b1}} : {{PAD_W{1'b0}}, cfg_i.span};
    end

    // Per-bit merge of the moving block bits with the fixed upper bits.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = blk_mask[b] ? pick[b] : base_i[b];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the burst column generator. Decodes the command-time burst
// setting, sequences the beats and drives column, valid and last.
// Assumes one command per cycle from the command path.
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             btype_i,
    input  logic             stop_i,
    input  logic             pre_term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);

    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_cur;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] cnt;
    logic             active;
    logic             fin;

    // Burst setting as seen on the command inputs.
    always_comb begin
        cfg_in = decode_cfg(blen_i, btype_i);
    end

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg_in),
        .stop_i      (stop_i),
        .pre_term_i  (pre_term_i),
        .active_o    (active),
        .base_o      (base),
        .cnt_o       (cnt),
        .cfg_o       (cfg_cur),
        .final_o     (fin)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .base_i (base),
        .cnt_i  (cnt),
        .cfg_i  (cfg_cur),
        .col_o  (col_o)
    );

    assign beat_vld_o = active;
    assign last_o     = fin;

endmodule

// File: rtl/colgen_chk.sv
// Property checker for the burst column generator, bound to the top.
// Latches its own copy of the burst setting at each start.
module colgen_chk
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_i,
    input logic             stop_i,
    input logic             pre_term_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o
);

    localparam int PAD_W = COL_W - 3;

    logic             page_q;
    logic [COL_W-1:0] up_mask_q;
    logic [COL_W-1:0] inc_col;
    logic             no_cmd;
    logic             one_beat_code;

    // Checker copy of the burst kind, taken when a burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= 1'b0;
            up_mask_q <= '0;
        end else if (start_i) begin
            page_q    <= (blen_i == LEN_PAGE);
            up_mask_q <= ~{{PAD_W{1'b0}}, span_of(blen_i)};
        end
    end

    assign inc_col       = col_o + COL_W'(1);
    assign no_cmd        = !start_i && !stop_i && !pre_term_i;
    assign one_beat_code = (blen_i == 3'd0) || (blen_i == 3'd4) || (blen_i == 3'd5) || (blen_i == 3'd6);

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

    // R5
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !last_o && !page_q && no_cmd) |=>
        (beat_vld_o && ((col_o & up_mask_q) == ($past(col_o) & up_mask_q))));

    // R6
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && one_beat_code) |=> last_o);

    // R7
    last_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    // R7
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);

    // R8
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && page_q && no_cmd) |=> (beat_vld_o && col_o == $past(inc_col)));

    // R8
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && page_q) |-> !last_o);

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !beat_vld_o);

    // R10
    pre_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_term_i && !start_i) |=> !beat_vld_o);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .stop_i      (stop_i),
    .pre_term_i  (pre_term_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;

    localparam int COL_W = 8;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       blen_i = '0;
    logic             btype_i = 1'b0;
    logic             stop_i = 1'b0;
    logic             pre_term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o;
    logic             last_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    exp_col[$];
    bit    exp_last[$];
    string exp_req[$];

    always #2 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .btype_i(btype_i), .stop_i(stop_i), .pre_term_i(pre_term_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
    );

    // Expected column of beat k, from the ordering rules (R3, R4, R6, R8).
    function automatic int model_col(int st, int code, bit ilv, int k);
        int size, mask;
        if (code == 7) return (st + k) % PAGE;
        size = (code >= 1 && code <= 3) ? (1 << code) : 1;
        mask = size - 1;
        if (ilv) return (st & ~mask) | ((st ^ k) & mask);
        return (st & ~mask) | ((st + k) & mask);
    endfunction

    function automatic int beats_of(int code);
        if (code == 7) return -1;
        return (code >= 1 && code <= 3) ? (1 << code) : 1;
    endfunction

    // Monitor: pops one expected beat per valid cycle and compares.
    always @(negedge clk) begin
        if (rst_n && !done && beat_vld_o) begin
            checks++;
            if (exp_col.size() == 0) begin
                failures++;
                $display("FAIL R7/R9/R10/R11: unexpected beat col=%0h last=%0b, expected no beat", col_o, last_o);
            end else begin
                int c; bit l; string r;
                c = exp_col.pop_front(); l = exp_last.pop_front(); r = exp_req.pop_front();
                if (int'(col_o) != c || last_o != l) begin
                    failures++;
                    $display("FAIL %s: col=%0h last=%0b expected col=%0h last=%0b", r, col_o, last_o, c, l);
                end
            end
        end
    end

    // Checks that no beat is present at this moment.
    task automatic check_idle(string req);
        checks++;
        if (beat_vld_o !== 1'b0 || last_o !== 1'b0) begin
            failures++;
            $display("FAIL %s: vld=%0b last=%0b expected vld=0 last=0", req, beat_vld_o, last_o);
        end
    endtask

    // Driver: issues a burst, queues the n beats expected, then ends it.
    // mode 0: runs to natural end, 1: burst stop, 2: precharge, 3: return for a new start.
    task automatic burst(int st, int code, bit ilv, int n, int mode, string req);
        int span = beats_of(code) - 1;
        for (int k = 0; k < n; k++) begin
            exp_col.push_back(model_col(st, code, ilv, k));
            exp_last.push_back(code != 7 && k == span);
            exp_req.push_back(req);
        end
        start_i = 1'b1; start_col_i = COL_W'(st); blen_i = 3'(code); btype_i = ilv;
        @(posedge clk); #1;
        start_i = 1'b0; stop_i = 1'b0; pre_term_i = 1'b0;
        blen_i = 3'd6; btype_i = ~ilv; start_col_i = '1;
        repeat (n - 1) begin @(posedge clk); #1; end
        if (mode == 1) stop_i = 1'b1;
        if (mode == 2) pre_term_i = 1'b1;
        if (mode != 3) begin
            @(posedge clk); #1;
            stop_i = 1'b0; pre_term_i = 1'b0;
            check_idle(req);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check_idle("R1");
        // R9: stop while idle changes nothing
        stop_i = 1'b1; @(posedge clk); #1; stop_i = 1'b0;
        check_idle("R9");
        // R2 R3: sequential 4, 2, 8 with wrap inside the block
        burst('h35, 2, 0, 4, 0, "R3");
        burst('h0B, 1, 0, 2, 0, "R2");
        burst('h2D, 3, 0, 8, 0, "R3");
        // R4 R5: interleaved 8 and 4
        burst('h13, 3, 1, 8, 0, "R4");
        burst('hC2, 2, 1, 4, 0, "R5");
        // R6: one beat for code 0 and unused code 5
        burst('h77, 0, 1, 1, 0, "R6");
        burst('h5A, 5, 0, 1, 0, "R6");
        // R8: full page, interleaved flag ignored, wraps past the page end
        burst(250, 7, 1, 262, 1, "R8");
        // R9: burst stop after 3 of 8 beats
        burst('h10, 3, 0, 3, 1, "R9");
        // R10: precharge after 2 of 4 beats
        burst('h66, 2, 1, 2, 2, "R10");
        // R11: new start after 3 beats, with a stop in the same cycle
        burst('h20, 3, 0, 3, 3, "R11");
        stop_i = 1'b1;
        burst('h81, 2, 0, 4, 0, "R11");
        // R12: back-to-back bursts with no gap; R7 last then end
        burst('h04, 1, 0, 2, 3, "R12");
        burst('h09, 1, 1, 2, 0, "R7");
        repeat (2) begin @(posedge clk); #1; end
        checks++;
        if (exp_col.size() != 0) begin
            failures++;
            $display("FAIL R2: missing beats=%0d expected 0", exp_col.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: cycles=20000 expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule